// File: doc/BRIEF.md
# Parallel Port Register and Bit-Set Unit

This block is the processor-side register file of a three-port, 24-line parallel I/O adapter. A host reads and writes it through an active-low chip select, active-low read and write strobes, a 2-bit address, and separate 8-bit write and read data buses. The block holds the output registers for ports A, B and C and a 7-bit control word. It drives one output enable for each of ports A and B and one enable for each port C line. For reads it selects the live pins, the output registers, the handshake status bits or the control word.

A write to the control address has two meanings, chosen by bit 7. With bit 7 set, the write defines the mode and direction of every port. With bit 7 clear, the write changes a single port C bit. Handshake flags are produced by separate strobe logic outside this block. That logic returns its status byte on `hs_status`, and the block shows those bits on the port C lines that the active modes reserve for handshaking.

The write strobe passes through a two-stage synchronizer. A small write-strobe state machine then produces the commit pulse. It has two states: `WS_IDLE`, in which it waits for the synchronized strobe to go low, and `WS_ARMED`, in which it waits for the strobe to return high. There are two transitions. IDLE to ARMED is taken when the synchronized strobe is low. ARMED to IDLE is taken when the strobe is high, and a one-cycle commit is raised in that same cycle if chip select is low.

Top module: `ppi_regs`

## Requirements
- R1: After reset the control word reads 0x9B, meaning every port is in basic mode and set as input. All three output registers are 0x00, and `a_oe`, `b_oe` and `c_oe` are all 0.
- R2: A committed write goes to the register chosen by `addr`: 0 is port A, 1 is port B, 2 is port C and 3 is control. Only that register changes.
- R3: A control write with bit 7 = 1 loads the mode and direction fields, where 1 means input. Bit 0 is the port C low-nibble direction, bit 1 the port B direction, bit 2 the group B mode (0 basic, 1 strobed), bit 3 the port C high-nibble direction and bit 4 the port A direction. Bits 6:5 are the group A mode: 00 basic, 01 strobed, 1x bidirectional. `a_oe` = 1 when port A is an output and group A is not bidirectional. `b_oe` = 1 when port B is an output.
- R4: A control write with bit 7 = 0 writes bit 0 into the port C output bit selected by bits 3:1. Bits 6:4 are ignored and the control word does not change. This works in every mode.
- R5: A read of address 3 returns the control word with bit 7 forced to 1.
- R6: While group A or group B is in a strobed or bidirectional mode, a byte write to address 2 leaves the port C output register unchanged.
- R7: A read of port A or B returns the live input pins when the port is not driving, and the output register when it is. Each port C line not reserved for handshaking behaves the same way, bit by bit.
- R8: A mode-definition write leaves the contents of all three output registers unchanged.
- R9: A write commits only in the cycle after the synchronized write strobe returns high, and only if `cs_n` is low in that cycle. A strobe pulse with `cs_n` high changes nothing.
- R10: `c_oe` follows the direction bits on lines not reserved for handshaking. The reserved lines are driven as follows:
  - Group A strobed: line 3 is driven. With port A as input, line 4 is undriven and line 5 is driven. With port A as output, line 6 is undriven and line 7 is driven.
  - Group A bidirectional: lines 7..3 are driven as 1,0,1,0,1.
  - Group B strobed: lines 0 and 1 are driven and line 2 is undriven.
- R11: `rdata` is 0x00 unless `cs_n` and `rd_n` are both low.
- R12: A read of port C returns the `hs_status` bit on every line reserved for handshaking by the active modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the write commits after its rising edge |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data to the host |
| a_pins | input | 8 | Port A pin inputs |
| b_pins | input | 8 | Port B pin inputs |
| c_pins | input | 8 | Port C pin inputs |
| hs_status | input | 8 | Handshake status byte from the strobe logic |
| a_out | output | 8 | Port A output register |
| b_out | output | 8 | Port B output register |
| c_out | output | 8 | Port C output register |
| a_oe | output | 1 | Port A output enable |
| b_oe | output | 1 | Port B output enable |
| c_oe | output | 8 | Per-line port C output enables |

## Verification
A read and a committed write can happen in the same cycle, because the read path is combinational and the commit lands on a clock edge. The bench holds `rd_n` and `cs_n` low on port A throughout a write to port A. It samples `rdata` once in the commit cycle, where it expects the old register value, and once after the next edge, where it expects the new one. A single-bit write can also meet a mode that blocks byte writes. The bench places a blocked byte write and a bit set back to back under strobed modes and expects only the bit change to appear.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } reg_sel_e;

    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_ARMED = 1'b1
    } wr_state_e;

    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       c_hi_in;
        logic       b_mode;
        logic       b_in;
        logic       c_lo_in;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = 7'h1B;

endpackage

// File: rtl/ppi_wr_fsm.sv
module ppi_wr_fsm #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_n,
    input  logic cs_n,
    output logic commit
);
    import ppi_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   wr_s;
    wr_state_e              state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], wr_n};
    end
    assign wr_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) state_q <= WS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (!wr_s) state_d = WS_ARMED;
            WS_ARMED: if (wr_s)  state_d = WS_IDLE;
            default:             state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            WS_IDLE:  commit = 1'b0;
            WS_ARMED: commit = wr_s && !cs_n;
            default:  commit = 1'b0;
        endcase
    end

    // R9: the commit pulse lasts exactly one cycle per strobe
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

endmodule

// File: rtl/ppi_port_regs.sv
module ppi_port_regs
    import ppi_pkg::*;
#(
    parameter int W = ppi_pkg::DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output ctrl_t        ctrl,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] c_out
);
    localparam int BSW = $clog2(W);

    logic hs_any;
    assign hs_any = (ctrl.a_mode != 2'b00) || ctrl.b_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            a_out <= '0;
            b_out <= '0;
            c_out <= '0;
        end else if (commit) begin
            unique case (reg_sel_e'(addr))
                SEL_A: a_out <= wdata;
                SEL_B: b_out <= wdata;
                SEL_C: if (!hs_any) c_out <= wdata;
                SEL_CTRL: begin
                    if (wdata[W-1]) ctrl <= ctrl_t'(wdata[W-2:0]);
                    else            c_out[wdata[BSW:1]] <= wdata[0];
                end
                default: ;
            endcase
        end
    end

    // R6: byte writes to port C are blocked in handshake modes
    a_r6_c_blocked: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == 2'b10 && hs_any) |=> $stable(c_out));
    // R4: a bit set/reset never touches the control word
    a_r4_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == 2'b11 && !wdata[W-1]) |=> $stable(ctrl));
    // R8: mode definition keeps every output register
    a_r8_outs_kept: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == 2'b11 && wdata[W-1]) |=>
            ($stable(a_out) && $stable(b_out) && $stable(c_out)));
    // R2: a port A write leaves the other ports alone
    a_r2_a_only: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == 2'b00) |=> ($stable(b_out) && $stable(c_out)));
    // R1: first cycle out of reset holds the reset control word
    a_r1_reset_ctrl: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl == CTRL_RESET && a_out == '0));

endmodule

// File: rtl/ppi_oe_map.sv
module ppi_oe_map
    import ppi_pkg::*;
(
    input  ctrl_t      ctrl,
    output logic       a_oe,
    output logic       b_oe,
    output logic [7:0] c_oe,
    output logic [7:0] c_hs_mask
);
    logic ga_bidir, ga_strobe;

    assign ga_bidir  = ctrl.a_mode[1];
    assign ga_strobe = (ctrl.a_mode == 2'b01);
    assign a_oe      = !ctrl.a_in && !ga_bidir;
    assign b_oe      = !ctrl.b_in;

    always_comb begin
        c_oe      = {{4{!ctrl.c_hi_in}}, {4{!ctrl.c_lo_in}}};
        c_hs_mask = '0;
        if (ga_bidir) begin
            c_oe[7:3]      = 5'b10101;
            c_hs_mask[7:3] = '1;
        end else if (ga_strobe) begin
            c_oe[3]      = 1'b1;
            c_hs_mask[3] = 1'b1;
            if (ctrl.a_in) begin
                c_oe[5:4]      = 2'b10;
                c_hs_mask[5:4] = 2'b11;
            end else begin
                c_oe[7:6]      = 2'b10;
                c_hs_mask[7:6] = 2'b11;
            end
        end
        if (ctrl.b_mode) begin
            c_oe[2:0]      = 3'b011;
            c_hs_mask[2:0] = 3'b111;
        end
    end

endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
    import ppi_pkg::*;
#(
    parameter int W = ppi_pkg::DW
) (
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic [1:0]   addr,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] a_out,
    input  logic [W-1:0] b_out,
    input  logic [W-1:0] c_out,
    input  logic [W-1:0] a_pins,
    input  logic [W-1:0] b_pins,
    input  logic [W-1:0] c_pins,
    input  logic [W-1:0] hs_status,
    input  logic         a_oe,
    input  logic         b_oe,
    input  logic [W-1:0] c_oe,
    input  logic [W-1:0] c_hs_mask,
    output logic [W-1:0] rdata
);
    logic [W-1:0] c_view;

    for (genvar i = 0; i < W; i++) begin : g_cbit
        assign c_view[i] = c_hs_mask[i] ? hs_status[i]
                         : (c_oe[i] ? c_out[i] : c_pins[i]);
    end

    always_comb begin
        rdata = '0;
        if (!cs_n && !rd_n) begin
            unique case (reg_sel_e'(addr))
                SEL_A:    rdata = a_oe ? a_out : a_pins;
                SEL_B:    rdata = b_oe ? b_out : b_pins;
                SEL_C:    rdata = c_view;
                SEL_CTRL: rdata = {1'b1, ctrl};
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
    import ppi_pkg::*;
#(
    parameter int W           = ppi_pkg::DW,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] a_pins,
    input  logic [W-1:0] b_pins,
    input  logic [W-1:0] c_pins,
    input  logic [W-1:0] hs_status,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] c_out,
    output logic         a_oe,
    output logic         b_oe,
    output logic [W-1:0] c_oe
);
    logic  commit;
    ctrl_t ctrl;
    logic [W-1:0] c_hs_mask;

    ppi_wr_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_wr (
        .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .commit(commit)
    );

    ppi_port_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .commit(commit), .addr(addr), .wdata(wdata),
        .ctrl(ctrl), .a_out(a_out), .b_out(b_out), .c_out(c_out)
    );

    ppi_oe_map u_oe (
        .ctrl(ctrl), .a_oe(a_oe), .b_oe(b_oe), .c_oe(c_oe),
        .c_hs_mask(c_hs_mask)
    );

    ppi_read_mux #(.W(W)) u_rd (
        .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .ctrl(ctrl),
        .a_out(a_out), .b_out(b_out), .c_out(c_out),
        .a_pins(a_pins), .b_pins(b_pins), .c_pins(c_pins),
        .hs_status(hs_status), .a_oe(a_oe), .b_oe(b_oe), .c_oe(c_oe),
        .c_hs_mask(c_hs_mask), .rdata(rdata)
    );

    // R11: the read bus is quiet when no read is selected
    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (rdata == '0));
    // R10: bidirectional group A never drives lines 4 and 6
    a_r10_bidir_inputs: assert property (@(posedge clk) disable iff (rst)
        (a_out == a_out && u_regs.ctrl.a_mode[1]) |-> (!c_oe[4] && !c_oe[6] && !a_oe));

endmodule

// File: tb/sim_ppi_regs.sv
`timescale 1ns/1ps
module sim_ppi_regs;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, a_pins = '0, b_pins = '0, c_pins = '0, hs_status = '0;
    logic [7:0] rdata, a_out, b_out, c_out, c_oe;
    logic a_oe, b_oe;

    always #2 clk = ~clk;

    ppi_regs u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .a_pins(a_pins),
        .b_pins(b_pins), .c_pins(c_pins), .hs_status(hs_status),
        .a_out(a_out), .b_out(b_out), .c_out(c_out), .a_oe(a_oe),
        .b_oe(b_oe), .c_oe(c_oe)
    );

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  ev;
    int    checks = 0, fails = 0;
    bit    done = 0;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0:       return rdata;
            1:       return a_out;
            2:       return b_out;
            3:       return c_out;
            4:       return c_oe;
            default: return {6'b0, a_oe, b_oe};
        endcase
    endfunction

    initial begin
        forever begin
            @(ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it  = q.pop_front();
                got = observe(it.sel);
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic expect_obs(int sel, logic [7:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        ->ev;
        #1;
    endtask

    task automatic rd_check(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        cs_n = 0; rd_n = 0; addr = a;
        #0.5;
        expect_obs(0, exp, tag);
        @(negedge clk);
        cs_n = 1; rd_n = 1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, bit sel);
        @(negedge clk);
        cs_n = !sel; addr = a; wdata = d; wr_n = 0;
        repeat (3) @(negedge clk);
        wr_n = 1;
        repeat (4) @(negedge clk);
        cs_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd_check(2'd3, 8'h9B, "R1 ctrl after reset");
        expect_obs(1, 8'h00, "R1 a_out reset");
        expect_obs(3, 8'h00, "R1 c_out reset");
        expect_obs(4, 8'h00, "R1 c_oe reset");
        expect_obs(5, 8'h00, "R1 a_oe/b_oe reset");
        // R7 live pins in input mode
        a_pins = 8'h5A;
        rd_check(2'd0, 8'h5A, "R7 port A live pins");
        a_pins = 8'hC3;
        rd_check(2'd0, 8'hC3, "R7 port A pins follow");
        // R11 no read strobe
        @(negedge clk); cs_n = 0; rd_n = 1; addr = 2'd3; #0.5;
        expect_obs(0, 8'h00, "R11 quiet bus");
        cs_n = 1;
        // R3 all outputs basic mode
        wr(2'd3, 8'h80, 1);
        expect_obs(5, 8'h03, "R3 a_oe/b_oe outputs");
        expect_obs(4, 8'hFF, "R3 c_oe outputs");
        rd_check(2'd3, 8'h80, "R5 ctrl readback");
        // R2 port writes
        wr(2'd0, 8'h11, 1);
        wr(2'd1, 8'h22, 1);
        wr(2'd2, 8'h33, 1);
        expect_obs(1, 8'h11, "R2 a_out");
        expect_obs(2, 8'h22, "R2 b_out");
        expect_obs(3, 8'h33, "R2 c_out");
        rd_check(2'd1, 8'h22, "R7 port B output readback");
        // R4 bit set / reset
        wr(2'd3, 8'h0F, 1);
        expect_obs(3, 8'hB3, "R4 set bit 7");
        wr(2'd3, 8'h72, 1);
        expect_obs(3, 8'hB1, "R4 clear bit 1 ignoring 6:4");
        rd_check(2'd3, 8'h80, "R4 ctrl unchanged");
        // strobed modes both groups, outputs
        wr(2'd3, 8'hA4, 1);
        expect_obs(4, 8'hBB, "R10 strobed out c_oe");
        expect_obs(1, 8'h11, "R8 a_out kept");
        expect_obs(3, 8'hB1, "R8 c_out kept");
        wr(2'd2, 8'h00, 1);
        wr(2'd3, 8'h0D, 1);
        expect_obs(3, 8'hF1, "R6 byte blocked, R4 bit 6 set");
        hs_status = 8'h5A; c_pins = 8'hFF;
        rd_check(2'd2, 8'h7A, "R12 status on reserved lines");
        // strobed A input
        wr(2'd3, 8'hB0, 1);
        expect_obs(4, 8'hEF, "R10 strobed in c_oe");
        // bidirectional
        wr(2'd3, 8'hC0, 1);
        expect_obs(4, 8'hAF, "R10 bidir c_oe");
        expect_obs(5, 8'h01, "R3 bidir a_oe off");
        wr(2'd3, 8'hE0, 1);
        rd_check(2'd3, 8'hE0, "R3 mode 1x readback");
        expect_obs(4, 8'hAF, "R3 mode 11 as bidir");
        // R9 strobe without select
        wr(2'd3, 8'h9B, 0);
        rd_check(2'd3, 8'hE0, "R9 unselected strobe ignored");
        // same-cycle read and commit on port A
        wr(2'd3, 8'h80, 1);
        @(negedge clk);
        cs_n = 0; rd_n = 0; addr = 2'd0; wdata = 8'h77; wr_n = 0;
        repeat (3) @(negedge clk);
        wr_n = 1;
        @(negedge clk);
        @(negedge clk); #0.5;
        expect_obs(0, 8'h11, "R9 old value in commit cycle");
        @(negedge clk); #0.5;
        expect_obs(0, 8'h77, "R2 new value after commit");
        cs_n = 1; rd_n = 1;
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule